// File: doc/BRIEF.md
# Power-fail chip-enable gating decoder

This block steers a single active-low chip-enable onto one of four active-low bank enables, picked by two select bits, so that several static RAM banks can share one enable line. The steering path is purely combinational while power is good, so the select bits may settle at the same moment the enable falls.

A power-fail flag, brought in through a two-flop synchronizer, moves the block into write protection, where every bank enable is held high whatever the chip-enable does. If an access is open when the failure is seen, it may finish: protection starts once chip-enable returns high, or when a timeout expires, whichever comes first. When the flag clears, every enable stays high for a long recovery interval before normal steering resumes. Reset also starts that recovery hold. A single down-counter times both the timeout and the recovery interval. Both lengths are parameters counted in clock cycles.

Top module: `pfce_gate`

## Requirements
- R1: While `ce_n_i` is high, all four bits of `bank_ce_n_o` are high for every value of `sel_i`.
- R2: In normal operation with `ce_n_i` low, exactly one bank enable is low. `sel_i[0]` is the A bit and `sel_i[1]` is the B bit. A=0,B=0 selects bit 0. A=1,B=0 selects bit 1. A=0,B=1 selects bit 2. A=1,B=1 selects bit 3.
- R3: In normal operation, a change on `ce_n_i` or `sel_i` reaches `bank_ce_n_o` with no clock edge in between.
- R4: `pwr_fail_i` passes through two flops, so the block acts on it at the third rising edge after it changes. With `ce_n_i` high at that edge, protection starts there.
- R5: If `ce_n_i` is low at the edge where the failure is acted on, the bank enables keep following `ce_n_i` and `sel_i`. Protection starts at the first rising edge that samples `ce_n_i` high.
- R6: An access left open after a failure is cut off. At the TMO_CYCLES-th rising edge after the failure is acted on, all enables are forced high even if `ce_n_i` is still low.
- R7: While protected, all enables are high regardless of `ce_n_i` and `sel_i`.
- R8: After `pwr_fail_i` falls, the enables stay high until REC_CYCLES rising edges after the edge where the fall is acted on. Normal steering resumes at that edge.
- R9: If `pwr_fail_i` rises again during the recovery hold, the block goes back to protection. The next recovery hold runs its full REC_CYCLES length again.
- R10: `rst_n` is a synchronous active-low reset that puts the block into the recovery hold with `prot_o` high. Normal steering starts at the REC_CYCLES-th rising edge after `rst_n` goes high.
- R11: `prot_o` is low in normal operation and while an open access is finishing. It is high while protected and during the recovery hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_fail_i | input | 1 | Asynchronous power-fail flag, high = supply out of tolerance |
| ce_n_i | input | 1 | Active-low chip-enable to steer |
| sel_i | input | 2 | Bank select; bit 0 = A, bit 1 = B |
| bank_ce_n_o | output | 4 | Conditioned active-low bank enables |
| prot_o | output | 1 | High while the banks are write-protected |

## Verification
The hardest situation to reach is a failure that arrives during an open access and then either ends normally or runs into the timeout. The stimulus holds `ce_n_i` low across the third edge after `pwr_fail_i` rises, so the block enters the finishing phase. It then either raises `ce_n_i` after a few cycles or keeps it low past TMO_CYCLES edges. A second difficult case is a failure that comes back in the middle of the recovery hold. The bench raises the flag partway through the count and then checks that the next hold still lasts its full length. Short timeout and recovery lengths are passed in as parameters so that every boundary edge can be sampled on both sides.

// File: rtl/pfce_pkg.sv
// Shared types for the power-fail chip-enable gate.
package pfce_pkg;
    // Controller states: steering, finishing an open access, protected, recovery hold.
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_PROT  = 2'd2,
        ST_RECOV = 2'd3
    } pfce_state_e;
endpackage

// File: rtl/pfce_sync.sv
// Multi-flop synchronizer for a single asynchronous level.
// Assumes the input is a slow level; clears to zero on reset.
module pfce_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pfce_timer.sv
// Shared down-counter for the timeout and recovery intervals.
// A load sets the count; it then falls by one per cycle and rests at zero.
// Reset loads RST_VAL so the reset recovery hold is timed at once.
module pfce_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt;

    // Load on request, else count down toward zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= CNT_W'(RST_VAL);
        else if (load_i)      cnt <= val_i;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);

    // R6 R8: an unloaded count steps down by exactly one
    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R8: an expired count stays expired until reloaded
    // R8
    cnt_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && zero_o) |=> zero_o);
endmodule

// File: rtl/pfce_ctrl.sv
// Power-fail state machine. Decides whether the chip-enable may pass,
// lets an open access finish within a bounded time, and enforces the
// recovery hold. Assumes pf_i is already synchronized to clk.
module pfce_ctrl
    import pfce_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int TMO_CYCLES = 16,
    parameter int REC_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pf_i,
    input  logic             ce_n_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             pass_o,
    output logic             prot_o
);
    localparam logic [CNT_W-1:0] TMO_LOAD = CNT_W'(TMO_CYCLES - 1);
    localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_CYCLES - 1);

    pfce_state_e state, state_nx;

    // Next-state and counter-load selection.
    always_comb begin
        state_nx   = state;
        tmr_load_o = 1'b0;
        tmr_val_o  = REC_LOAD;
        unique case (state)
            ST_RUN: begin
                if (pf_i) begin
                    if (!ce_n_i) begin
                        state_nx   = ST_DRAIN;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = TMO_LOAD;
                    end else begin
                        state_nx = ST_PROT;
                    end
                end
            end
            ST_DRAIN: begin
                if (ce_n_i || tmr_zero_i) state_nx = ST_PROT;
            end
            ST_PROT: begin
                if (!pf_i) begin
                    state_nx   = ST_RECOV;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = REC_LOAD;
                end
            end
            ST_RECOV: begin
                if (pf_i)            state_nx = ST_PROT;
                else if (tmr_zero_i) state_nx = ST_RUN;
            end
            default: state_nx = ST_PROT;
        endcase
    end

    // State register; reset enters the recovery hold.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RECOV;
        else        state <= state_nx;
    end

    assign pass_o = (state == ST_RUN) || (state == ST_DRAIN);
    assign prot_o = (state == ST_PROT) || (state == ST_RECOV);

    // R6
    drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && tmr_zero_i) |=> (state == ST_PROT));

    // R5
    drain_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && ce_n_i) |=> (state == ST_PROT));

    // R9
    recov_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOV && pf_i) |=> (state == ST_PROT));

    // R8: protection never returns to steering without a recovery hold
    // R8
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROT) |=> (state == ST_PROT || state == ST_RECOV));

    // R11
    prot_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({pass_o, prot_o}));
endmodule

// File: rtl/pfce_decode.sv
// Combinational one-of-N steering of an active-low enable.
// Output g goes low only when enabled, ce_n_i is low and sel_i equals g.
module pfce_decode #(
    parameter int NBANK = 4,
    parameter int SEL_W = 2
) (
    input  logic             en_i,
    input  logic             ce_n_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [NBANK-1:0] bank_ce_n_o
);
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        // Drive one bank enable low on a matching select.
        assign bank_ce_n_o[g] = ~(en_i & ~ce_n_i & (sel_i == SEL_W'(g)));
    end
endmodule

// File: rtl/pfce_gate.sv
// Power-fail chip-enable gating decoder (top).
// Steers ce_n_i to one of NBANK bank enables and write-protects all of them
// around a power failure. TMO_CYCLES and REC_CYCLES are clock counts.
// Assumes ce_n_i stays high for at least one clock when an access ends.
module pfce_gate #(
    parameter int NBANK      = 4,
    parameter int TMO_CYCLES = 5000,
    parameter int REC_CYCLES = 4000000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwr_fail_i,
    input  logic                     ce_n_i,
    input  logic [$clog2(NBANK)-1:0] sel_i,
    output logic [NBANK-1:0]         bank_ce_n_o,
    output logic                     prot_o
);
    localparam int SEL_W  = $clog2(NBANK);
    localparam int MAXCNT = (TMO_CYCLES > REC_CYCLES) ? TMO_CYCLES : REC_CYCLES;
    localparam int CNT_W  = $clog2(MAXCNT + 1);

    logic             pf_s;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             pass;

    pfce_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pwr_fail_i),
        .q_o   (pf_s)
    );

    pfce_timer #(.CNT_W(CNT_W), .RST_VAL(REC_CYCLES - 1)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    pfce_ctrl #(
        .CNT_W      (CNT_W),
        .TMO_CYCLES (TMO_CYCLES),
        .REC_CYCLES (REC_CYCLES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pf_i       (pf_s),
        .ce_n_i     (ce_n_i),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .pass_o     (pass),
        .prot_o     (prot_o)
    );

    pfce_decode #(.NBANK(NBANK), .SEL_W(SEL_W)) u_dec (
        .en_i        (pass),
        .ce_n_i      (ce_n_i),
        .sel_i       (sel_i),
        .bank_ce_n_o (bank_ce_n_o)
    );

    // R2
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bank_ce_n_o));

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i |-> (bank_ce_n_o == '1));

    // R7
    prot_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_o |-> (bank_ce_n_o == '1));
endmodule

// File: tb/pfce_gate_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module pfce_gate_bench;
    localparam int TMO = 20;
    localparam int REC = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pf = 1'b0;
    logic       ce_n = 1'b1;
    logic [1:0] sel = 2'd0;
    logic [3:0] bank;
    logic       prot;

    int checks = 0;
    int fails  = 0;

    pfce_gate #(.NBANK(4), .TMO_CYCLES(TMO), .REC_CYCLES(REC)) u_pfce_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_fail_i  (pf),
        .ce_n_i      (ce_n),
        .sel_i       (sel),
        .bank_ce_n_o (bank),
        .prot_o      (prot)
    );

    always #10 clk = ~clk;

    function automatic logic [3:0] steer(input logic c, input logic [1:0] s);
        logic [3:0] r = 4'hF;
        if (!c) r[s] = 1'b0;
        return r;
    endfunction

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        edges(3);
        chk("R10 prot in reset", {3'b0, prot}, 4'h1);
        chk("R10 banks in reset", bank, 4'hF);
        rst_n = 1'b1;
        edges(REC - 1);
        ce_n = 1'b0; sel = 2'd1; #1;
        chk("R10 hold before end", bank, 4'hF);
        chk("R11 prot in hold", {3'b0, prot}, 4'h1);
        edges(1); #1;
        chk("R10 steering after hold", bank, 4'hD);
        ce_n = 1'b1;
    endtask

    task automatic t_decode();
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s); ce_n = 1'b1; #1;
            chk("R1 idle all high", bank, 4'hF);
            ce_n = 1'b0; #1;
            chk("R2 R3 one bank low", bank, steer(1'b0, 2'(s)));
        end
        sel = 2'd2; #1;
        chk("R3 select change without edge", bank, 4'hB);
        chk("R11 prot low while running", {3'b0, prot}, 4'h0);
        ce_n = 1'b1; #1;
        chk("R1 release", bank, 4'hF);
    endtask

    task automatic t_recover_to_run(input logic [1:0] s);
        pf = 1'b0;
        edges(3);
        ce_n = 1'b0; sel = s; #1;
        chk("R8 recovery entered", bank, 4'hF);
        edges(REC - 1); #1;
        chk("R8 hold before end", bank, 4'hF);
        edges(1); #1;
        chk("R8 steering resumed", bank, steer(1'b0, s));
        chk("R11 prot after recovery", {3'b0, prot}, 4'h0);
        ce_n = 1'b1;
    endtask

    task automatic t_pf_idle();
        ce_n = 1'b1; pf = 1'b1;
        edges(2);
        chk("R4 not yet acted on", {3'b0, prot}, 4'h0);
        edges(1);
        chk("R4 protected at third edge", {3'b0, prot}, 4'h1);
        ce_n = 1'b0; sel = 2'd3; #1;
        chk("R7 ce ignored", bank, 4'hF);
        sel = 2'd0; #1;
        chk("R7 select ignored", bank, 4'hF);
        ce_n = 1'b1;
        t_recover_to_run(2'd0);
    endtask

    task automatic t_drain_end();
        sel = 2'd2; ce_n = 1'b0; pf = 1'b1;
        edges(3); #1;
        chk("R5 open access continues", bank, 4'hB);
        chk("R11 prot low while finishing", {3'b0, prot}, 4'h0);
        edges(2); #1;
        chk("R5 still finishing", bank, 4'hB);
        ce_n = 1'b1; #1;
        chk("R5 access ends", bank, 4'hF);
        edges(1);
        chk("R5 protected after end", {3'b0, prot}, 4'h1);
        ce_n = 1'b0; #1;
        chk("R7 new access blocked", bank, 4'hF);
        ce_n = 1'b1;
        t_recover_to_run(2'd1);
    endtask

    task automatic t_drain_timeout();
        sel = 2'd3; ce_n = 1'b0; pf = 1'b1;
        edges(3); #1;
        chk("R6 finishing entered", bank, 4'h7);
        edges(TMO - 1); #1;
        chk("R6 before timeout", bank, 4'h7);
        edges(1); #1;
        chk("R6 forced at timeout", bank, 4'hF);
        chk("R6 prot at timeout", {3'b0, prot}, 4'h1);
        ce_n = 1'b1;
        t_recover_to_run(2'd3);
    endtask

    task automatic t_recov_restart();
        ce_n = 1'b1; pf = 1'b1;
        edges(3);
        pf = 1'b0;
        edges(3 + 10);
        pf = 1'b1;
        edges(3);
        ce_n = 1'b0; #1;
        chk("R9 back to protection", bank, 4'hF);
        chk("R9 prot high", {3'b0, prot}, 4'h1);
        ce_n = 1'b1;
        t_recover_to_run(2'd2);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_pf_idle();
        t_drain_end();
        t_drain_timeout();
        t_recov_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule